// File: doc/BRIEF.md
# Address-Sequence Nonvolatile Command Detector

This controller sits between a host bus and an SRAM array that has a nonvolatile shadow. It samples the chip enable, write enable, output enable, address and a low-supply flag once per clock. It watches read cycles opened by a falling chip enable for a fixed chain of five unlock addresses. The address of the sixth such read decides the command: one code asks for a copy of the SRAM into the nonvolatile cells (store), and another asks for the reverse copy (recall). Any other sixth address starts nothing.

When a command starts, the block emits a one-cycle request and raises `busy` for a fixed, parameter-set number of cycles. During that window it closes the array to all host reads and writes. A recall splits its window into two parts: a clear phase first, then a load phase. `clear_phase` tells the array which part is running. Two guards protect writes. A low-supply flag blocks every write and any store. A write that was already held active when reset released, or when a command started, stays blocked until E or W shows a new falling edge.

Top module: `nvcmd_guard`

## Requirements
- R1: While reset is high and in the first sampled cycle after it, `store_req`, `recall_req`, `busy`, `clear_phase` and `write_en` are 0.
- R2: A read is a cycle where `ce_n` falls (1 in the previous sample, 0 now) while `we_n` is 1. Reading 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 gives a one-cycle `store_req` in the clock edge that samples the sixth falling `ce_n`. `recall_req` stays low, and no request occurs without such a chain.
- R3: The same five reads followed by 0x0C63 give a one-cycle `recall_req` in the edge that samples the sixth falling `ce_n`.
- R4: A read of an address other than the next expected one sends the matcher back to the start. If that address is 0x0E38, it counts as the first step. Only a falling `ce_n` advances the matcher.
- R5: A write cycle anywhere in the chain breaks it. A write cycle is a falling `ce_n` while `we_n` is 0, or a falling `we_n` while `ce_n` is 0. After a break, the remaining addresses start nothing.
- R6: `busy` rises together with a request and stays high for exactly STORE_CYC cycles after a store and RECALL_CYC cycles after a recall. While `busy` is high, `sram_access_en`, `out_en` and `write_en` are 0, and reads do not advance the matcher.
- R7: During a recall, `clear_phase` is high for exactly the first CLEAR_CYC cycles of the `busy` window and low during the rest.
- R8: While `vlow` is 1, `write_en` stays 0 and a completed store chain starts nothing (`busy` stays 0). A recall chain still starts a recall.
- R9: If E and W are held low from reset onward, `write_en` stays 0 until `ce_n` or `we_n` shows a falling edge. The same holds after a command if W is held low through it: once `busy` drops, `write_en` stays 0 until a new falling edge.
- R10: Outside `busy`, `sram_access_en` follows `!ce_n` with one cycle of latency. `out_en` is `sram_access_en` gated by `we_n`=1 and `oe_n`=0. The sixth read of a command chain gets no access and no output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Sampled chip enable, active low |
| we_n | input | 1 | Sampled write enable, active low |
| oe_n | input | 1 | Sampled output enable, active low |
| addr | input | ADDR_W | Sampled address bus |
| vlow | input | 1 | Supply below the safe threshold |
| store_req | output | 1 | One-cycle start of a store |
| recall_req | output | 1 | One-cycle start of a recall |
| busy | output | 1 | Nonvolatile operation in progress |
| clear_phase | output | 1 | Recall is in its clearing part |
| sram_access_en | output | 1 | Array may be accessed this cycle |
| out_en | output | 1 | Data output drivers enabled |
| write_en | output | 1 | Array write strobe permitted |

## Verification
The assertions assume that the control inputs are already synchronous to `clk`, with one sample per clock and no glitches inside a cycle. They also assume that `vlow` is a clean level that is low in the cycle after reset releases. The bench drives every input on the falling clock edge, so each value is stable when sampled. It holds each level for at least one full cycle, so every falling edge of E or W is seen as one sampled transition. It changes `vlow` only between bus cycles.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_STORE  = 2'd1,
    OP_RECALL = 2'd2
  } nv_op_t;

  // number of unlock reads that come before the selecting read
  localparam int UNLOCK_LEN = 5;

  localparam logic [15:0] STORE_CODE  = 16'h0FC0;
  localparam logic [15:0] RECALL_CODE = 16'h0C63;

  function automatic logic [15:0] unlock_code(input int idx);
    case (idx)
      0:       return 16'h0E38;
      1:       return 16'h31C7;
      2:       return 16'h03E0;
      3:       return 16'h3C1F;
      4:       return 16'h303F;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/nvcmd_edges.sv
module nvcmd_edges (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic we_n,
  output logic ce_fall,
  output logic we_fall,
  output logic rd_strobe,
  output logic wr_event
);
  logic ce_q, we_q;

  // reset to "low" history so a level held low is never taken as an edge
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q <= 1'b0;
      we_q <= 1'b0;
    end else begin
      ce_q <= ce_n;
      we_q <= we_n;
    end
  end

  assign ce_fall   = ce_q & ~ce_n;
  assign we_fall   = we_q & ~we_n;
  assign rd_strobe = ce_fall & we_n;
  assign wr_event  = (ce_fall & ~we_n) | (we_fall & ~ce_n);
endmodule

// File: rtl/nvcmd_matcher.sv
module nvcmd_matcher
  import nvcmd_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              rd_strobe,
  input  logic              wr_event,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vlow,
  output nv_op_t            start_op
);
  localparam int STEP_W = $clog2(UNLOCK_LEN + 1);
  localparam logic [ADDR_W-1:0] STORE_A  = ADDR_W'(STORE_CODE);
  localparam logic [ADDR_W-1:0] RECALL_A = ADDR_W'(RECALL_CODE);

  logic [STEP_W-1:0]     step_q, step_d;
  logic [UNLOCK_LEN-1:0] hit;
  logic                  exp_hit;

  genvar g;
  generate
    for (g = 0; g < UNLOCK_LEN; g++) begin : g_code
      localparam logic [ADDR_W-1:0] KEY = ADDR_W'(unlock_code(g));
      assign hit[g] = (addr == KEY);
    end
  endgenerate

  always_comb begin
    exp_hit = 1'b0;
    for (int i = 0; i < UNLOCK_LEN; i++) begin
      if (step_q == STEP_W'(i)) exp_hit = hit[i];
    end
  end

  always_comb begin
    step_d   = step_q;
    start_op = OP_NONE;
    if (!enable || wr_event) begin
      step_d = '0;
    end else if (rd_strobe) begin
      if (step_q == STEP_W'(UNLOCK_LEN)) begin
        if (addr == STORE_A && !vlow)  start_op = OP_STORE;
        else if (addr == RECALL_A)     start_op = OP_RECALL;
        step_d = (start_op == OP_NONE && hit[0]) ? STEP_W'(1) : '0;
      end else if (exp_hit) begin
        step_d = step_q + STEP_W'(1);
      end else begin
        step_d = hit[0] ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_d;
  end
endmodule

// File: rtl/nvcmd_timer.sv
module nvcmd_timer
  import nvcmd_pkg::*;
#(
  parameter int STORE_CYC  = 40,
  parameter int RECALL_CYC = 60,
  parameter int CLEAR_CYC  = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  nv_op_t start_op,
  output logic   busy_q,
  output logic   busy_d,
  output logic   clear_q
);
  localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rec_q, rec_d, clear_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_op == OP_STORE)           cnt_d = CNT_W'(STORE_CYC - 1);
    else if (start_op == OP_RECALL)     cnt_d = CNT_W'(RECALL_CYC - 1);
    else if (busy_q && cnt_q != '0)     cnt_d = cnt_q - CNT_W'(1);
  end

  assign busy_d  = (start_op != OP_NONE) | (busy_q & (cnt_q != '0));
  assign rec_d   = (start_op == OP_RECALL) ? 1'b1 :
                   (start_op == OP_STORE)  ? 1'b0 : rec_q;
  assign clear_d = busy_d & rec_d & (cnt_d >= CNT_W'(RECALL_CYC - CLEAR_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      rec_q   <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      rec_q   <= rec_d;
      clear_q <= clear_d;
    end
  end
endmodule

// File: rtl/nvcmd_guard.sv
module nvcmd_guard
  import nvcmd_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int STORE_CYC  = 40,
  parameter int RECALL_CYC = 60,
  parameter int CLEAR_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vlow,
  output logic              store_req,
  output logic              recall_req,
  output logic              busy,
  output logic              clear_phase,
  output logic              sram_access_en,
  output logic              out_en,
  output logic              write_en
);
  logic   ce_fall, we_fall, rd_strobe, wr_event;
  logic   busy_d, armed_q, armed_d, acc_d;
  nv_op_t start_op;

  nvcmd_edges u_edges (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .ce_fall   (ce_fall),
    .we_fall   (we_fall),
    .rd_strobe (rd_strobe),
    .wr_event  (wr_event)
  );

  nvcmd_matcher #(.ADDR_W(ADDR_W)) u_match (
    .clk       (clk),
    .rst       (rst),
    .enable    (~busy),
    .rd_strobe (rd_strobe),
    .wr_event  (wr_event),
    .addr      (addr),
    .vlow      (vlow),
    .start_op  (start_op)
  );

  nvcmd_timer #(
    .STORE_CYC  (STORE_CYC),
    .RECALL_CYC (RECALL_CYC),
    .CLEAR_CYC  (CLEAR_CYC)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start_op (start_op),
    .busy_q   (busy),
    .busy_d   (busy_d),
    .clear_q  (clear_phase)
  );

  // write arming: dropped when a command starts, set by a fresh edge when idle
  assign armed_d = (start_op != OP_NONE)             ? 1'b0 :
                   (!busy && (ce_fall || we_fall))   ? 1'b1 : armed_q;
  assign acc_d   = ~busy_d & ~ce_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q        <= 1'b0;
      store_req      <= 1'b0;
      recall_req     <= 1'b0;
      sram_access_en <= 1'b0;
      out_en         <= 1'b0;
      write_en       <= 1'b0;
    end else begin
      armed_q        <= armed_d;
      store_req      <= (start_op == OP_STORE);
      recall_req     <= (start_op == OP_RECALL);
      sram_access_en <= acc_d;
      out_en         <= acc_d & we_n & ~oe_n;
      write_en       <= acc_d & armed_d & ~we_n & ~vlow;
    end
  end
endmodule

// File: rtl/nvcmd_guard_chk.sv
module nvcmd_guard_chk (
  input logic clk,
  input logic rst,
  input logic vlow,
  input logic store_req,
  input logic recall_req,
  input logic busy,
  input logic clear_phase,
  input logic sram_access_en,
  input logic out_en,
  input logic write_en
);
  // R2
  req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_req, recall_req}));

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (store_req || recall_req) |=> !(store_req || recall_req));

  // R6
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (store_req || recall_req) |-> busy);

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (store_req || recall_req));

  // R6
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!sram_access_en && !out_en && !write_en));

  // R7
  clear_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clear_phase) |-> recall_req);

  // R7
  clear_busy_chk: assert property (@(posedge clk) disable iff (rst)
    clear_phase |-> busy);

  // R8
  lowv_store_chk: assert property (@(posedge clk) disable iff (rst)
    store_req |-> !$past(vlow));

  // R8
  lowv_write_chk: assert property (@(posedge clk) disable iff (rst)
    write_en |-> !$past(vlow));

  // R10
  outen_access_chk: assert property (@(posedge clk) disable iff (rst)
    out_en |-> sram_access_en);
endmodule

bind nvcmd_guard nvcmd_guard_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .vlow           (vlow),
  .store_req      (store_req),
  .recall_req     (recall_req),
  .busy           (busy),
  .clear_phase    (clear_phase),
  .sram_access_en (sram_access_en),
  .out_en         (out_en),
  .write_en       (write_en)
);

// File: tb/tb_nvcmd_guard.sv
`timescale 1ns/1ps
module tb_nvcmd_guard;
  import nvcmd_pkg::*;

  localparam int ADDR_W     = 15;
  localparam int STORE_CYC  = 40;
  localparam int RECALL_CYC = 60;
  localparam int CLEAR_CYC  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b0, we_n = 1'b0, oe_n = 1'b1, vlow = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic store_req, recall_req, busy, clear_phase, sram_access_en, out_en, write_en;

  nvcmd_guard #(
    .ADDR_W(ADDR_W), .STORE_CYC(STORE_CYC),
    .RECALL_CYC(RECALL_CYC), .CLEAR_CYC(CLEAR_CYC)
  ) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .vlow(vlow), .store_req(store_req), .recall_req(recall_req),
    .busy(busy), .clear_phase(clear_phase), .sram_access_en(sram_access_en),
    .out_en(out_en), .write_en(write_en)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    int    kind;   // 1 store, 2 recall
    int    at;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: every request pulse must match the next expected item
  always @(negedge clk) begin
    exp_t e;
    int k;
    if (!rst && (store_req || recall_req)) begin
      k = store_req ? 1 : 2;
      if (exp_q.size() == 0) begin
        chk("R2 unexpected request kind", k, 0);
      end else begin
        e = exp_q.pop_front();
        chk({e.tag, " request kind"}, k, e.kind);
        chk({e.tag, " request cycle"}, cyc, e.at);
      end
    end
  end

  // read cycle; kind != 0 pushes the request it must start
  task automatic bus_read(input logic [15:0] a, input int kind, input string tag);
    exp_t e;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    @(negedge clk); ce_n = 1'b0; addr = ADDR_W'(a);
    if (kind != 0) begin
      e.kind = kind; e.at = cyc + 1; e.tag = tag;
      exp_q.push_back(e);
    end
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [15:0] a);
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = ADDR_W'(a);
    @(negedge clk);
  endtask

  task automatic prefix();
    for (int i = 0; i < UNLOCK_LEN; i++) bus_read(unlock_code(i), 0, "");
  endtask

  task automatic wait_idle(output int n, output int nclr);
    n = 0; nclr = 0;
    while (busy) begin
      n++;
      if (clear_phase) nclr++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n, nclr;
    // reset with E and W held low
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 store_req after reset", store_req, 0);
    chk("R1 recall_req after reset", recall_req, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 clear_phase after reset", clear_phase, 0);
    chk("R1 write_en after reset", write_en, 0);
    repeat (3) @(negedge clk);
    chk("R9 held write blocked from reset", write_en, 0);
    chk("R10 access with E low", sram_access_en, 1);
    we_n = 1'b1; @(negedge clk);
    we_n = 1'b0; @(negedge clk);
    chk("R9 write armed by fresh W edge", write_en, 1);

    // R10 plain accesses
    bus_read(16'h1234, 0, "");
    chk("R10 read access", sram_access_en, 1);
    chk("R10 read out_en", out_en, 1);
    chk("R10 no write on read", write_en, 0);
    oe_n = 1'b1; @(negedge clk);
    chk("R10 out_en off with G high", out_en, 0);
    ce_n = 1'b1; @(negedge clk);
    chk("R10 access off with E high", sram_access_en, 0);

    // R2 store, W then held low through the command for R9
    prefix();
    chk("R2 prefix reads keep access", sram_access_en, 1);
    bus_read(STORE_CODE, 1, "R2");
    chk("R2 busy with store", busy, 1);
    chk("R10 sixth read gets no access", sram_access_en, 0);
    chk("R10 sixth read output off", out_en, 0);
    we_n = 1'b0;
    wait_idle(n, nclr);
    chk("R6 store busy length", n, STORE_CYC);
    chk("R7 no clear phase in store", nclr, 0);
    repeat (2) @(negedge clk);
    chk("R9 held write blocked after command", write_en, 0);
    chk("R10 access back after command", sram_access_en, 1);
    ce_n = 1'b1; @(negedge clk);
    ce_n = 1'b0; @(negedge clk);
    chk("R9 write armed by fresh E edge", write_en, 1);

    // R6 reads during busy are ignored
    prefix();
    bus_read(STORE_CODE, 1, "R6");
    prefix();
    chk("R6 access blocked while busy", sram_access_en, 0);
    wait_idle(n, nclr);
    bus_read(STORE_CODE, 0, "");
    chk("R6 chain read while busy starts nothing", busy, 0);

    // R3 recall and R7 clear phase
    prefix();
    bus_read(RECALL_CODE, 2, "R3");
    chk("R7 clear phase at recall start", clear_phase, 1);
    wait_idle(n, nclr);
    chk("R6 recall busy length", n, RECALL_CYC);
    chk("R7 clear phase length", nclr, CLEAR_CYC);

    // R4 restart on a repeated first code
    bus_read(16'h0E38, 0, ""); bus_read(16'h31C7, 0, "");
    prefix();
    bus_read(STORE_CODE, 1, "R4");
    wait_idle(n, nclr);
    bus_read(16'h0E38, 0, ""); bus_read(16'h31C7, 0, "");
    bus_read(16'h1111, 0, "");
    for (int i = 2; i < UNLOCK_LEN; i++) bus_read(unlock_code(i), 0, "");
    bus_read(STORE_CODE, 0, "");
    chk("R4 wrong address breaks chain", busy, 0);

    // R5 write in the chain
    for (int i = 0; i < 3; i++) bus_read(unlock_code(i), 0, "");
    bus_write(16'h0042);
    for (int i = 3; i < UNLOCK_LEN; i++) bus_read(unlock_code(i), 0, "");
    bus_read(STORE_CODE, 0, "");
    chk("R5 write breaks chain", busy, 0);

    // R8 low supply
    vlow = 1'b1;
    bus_write(16'h0007);
    chk("R8 write blocked at low supply", write_en, 0);
    prefix();
    bus_read(STORE_CODE, 0, "");
    chk("R8 store blocked at low supply", busy, 0);
    prefix();
    bus_read(RECALL_CODE, 2, "R8");
    chk("R8 recall allowed at low supply", busy, 1);
    wait_idle(n, nclr);
    vlow = 1'b0;

    repeat (4) @(negedge clk);
    chk("R2 all expected requests seen", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule